// File: doc/BRIEF.md
# Hibernation Power Sequencing Controller

This always-on controller decides when the main supply domain is switched off and when it is brought back. It drives an active-high `hib_o` output that tells an external regulator to remove main power. Hibernation starts either from a software request bit in a control word or from a main-supply-loss flag that arrives while the battery is reported valid. Once hibernating, the controller waits for any enabled wake source. The sources are a wake pin, a reset pin, a masked group of general-purpose inputs, and an RTC match pulse. When one fires, `hib_o` drops so that main power can be restored.

A low-battery input interacts with two policy bits. One policy refuses software hibernation requests while the battery is low. The other holds the controller in hibernation while the battery is low. A master clock-enable bit gates all activity. The source that caused each wake is kept in sticky cause bits, and software clears them with a write-one-to-clear mask. The RTC counter, the oscillators, battery sensing and power-on reset are outside the block and reach it only as input signals.

Top module: `hib_pwr_ctrl`

## Requirements
- R1: After reset, `hib_o` is 0, `req_pending` is 0 and `wake_cause` is 0.
- R2: The control word is written whole by `cfg_wr`. Its bit fields are: bit0 clock enable, bit1 hibernate request, bit2 wake-pin enable, bit3 reset-pin enable, bit4 GPIO enable, bit5 RTC enable, bit6 low-battery entry block, bit7 low-battery wake block. If the clock enable is set and the request bit is set, `hib_o` rises one cycle after the control word is registered.
- R3: With the clock enable set, `main_loss` and `bat_valid` both high cause `hib_o` to rise on the next cycle. `main_loss` alone does not.
- R4: While hibernating, a wake source that is active and enabled makes `hib_o` fall on the next cycle. The sources are `wake_pin`, `rst_pin`, any bit of `gpio_in` selected by `gpio_wake_mask`, and `rtc_match`.
- R5: A wake source whose enable bit is clear, or a GPIO bit that is masked off, leaves `hib_o` high.
- R6: Several sources may be enabled together, and any one of them alone wakes the controller.
- R7: If `bat_low` is high and the entry-block bit is set, a software request is refused: `hib_o` stays 0. Entry through supply loss is not blocked by this bit.
- R8: If `bat_low` is high and the wake-block bit is set, wake is suppressed. Wake proceeds once `bat_low` falls while a source is still active.
- R9: While the clock enable is clear, requests, supply loss and wake events have no effect, and the request bit stays pending.
- R10: `wake_cause` holds one sticky bit per source: bit0 wake pin, bit1 reset pin, bit2 GPIO, bit3 RTC. A bit is set when its source wakes the controller. A bit is cleared by a 1 in `sts_clr_mask` together with `sts_clr_wr`. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: The request bit (`req_pending`) clears itself on the cycle the controller consumes it, whether the request is accepted or refused. A `cfg_wr` in that same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word value (fields in R2) |
| gpio_wake_mask | input | GPIO_N | Per-bit wake enable for `gpio_in` |
| sts_clr_wr | input | 1 | Strobe for clearing cause bits |
| sts_clr_mask | input | 4 | Write-one-to-clear mask for `wake_cause` |
| main_loss | input | 1 | Main supply loss flag |
| bat_valid | input | 1 | Battery present and valid |
| bat_low | input | 1 | Battery below threshold |
| wake_pin | input | 1 | Wake pin, active high |
| rst_pin | input | 1 | Reset pin as a wake source, active high |
| gpio_in | input | GPIO_N | General-purpose wake inputs |
| rtc_match | input | 1 | RTC match pulse |
| hib_o | output | 1 | High while main power should be off |
| req_pending | output | 1 | Hibernate request bit of the control word |
| wake_cause | output | 4 | Sticky wake cause bits |

## Verification
The hardest situations to reach are the ones where two policies meet on the same edge. In the first, a wake source is held active across the fall of `bat_low` with the wake-block bit set. In the second, a wake sets a cause bit in the same cycle that a clear strobe targets it. The stimulus enters hibernation through a software request with the battery good, then raises `bat_low` and the wake pin together. It then drops `bat_low` while the pin stays high and the clear strobe is asserted on that edge. The expected result is a single wake with the cause bit kept.

// File: rtl/hib_pkg.sv
package hib_pkg;
   localparam int CTRL_W = 8;
   localparam int NSRC   = 4;

   localparam int SRC_PIN  = 0;
   localparam int SRC_RST  = 1;
   localparam int SRC_GPIO = 2;
   localparam int SRC_RTC  = 3;

   typedef enum logic {ST_RUN = 1'b0, ST_HIB = 1'b1} hib_state_e;

   typedef struct packed {
      logic lb_no_wake;
      logic lb_no_entry;
      logic en_rtc;
      logic en_gpio;
      logic en_rst;
      logic en_pin;
      logic hib_req;
      logic clk_en;
   } hib_ctrl_t;
endpackage

// File: rtl/hib_wake_arb.sv
module hib_wake_arb
   import hib_pkg::*;
#(
   parameter int GPIO_N = 4
) (
   input  logic [NSRC-1:0]   src_en,
   input  logic              wake_pin,
   input  logic              rst_pin,
   input  logic [GPIO_N-1:0] gpio_in,
   input  logic [GPIO_N-1:0] gpio_mask,
   input  logic              rtc_match,
   output logic [NSRC-1:0]   src_hit,
   output logic              any_hit
);
   logic gpio_any;

   generate
      if (GPIO_N == 1) begin : g_gpio_single
         assign gpio_any = gpio_in[0] & gpio_mask[0];
      end else begin : g_gpio_multi
         assign gpio_any = |(gpio_in & gpio_mask);
      end
   endgenerate

   always_comb begin
      src_hit           = '0;
      src_hit[SRC_PIN]  = wake_pin;
      src_hit[SRC_RST]  = rst_pin;
      src_hit[SRC_GPIO] = gpio_any;
      src_hit[SRC_RTC]  = rtc_match;
      src_hit           = src_hit & src_en;
   end

   assign any_hit = |src_hit;
endmodule

// File: rtl/hib_seq.sv
module hib_seq
   import hib_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clk_en,
   input  logic hib_req,
   input  logic lb_no_entry,
   input  logic lb_no_wake,
   input  logic bat_low,
   input  logic main_loss,
   input  logic bat_valid,
   input  logic any_hit,
   output logic hib_o,
   output logic req_clr,
   output logic wake_take
);
   hib_state_e st_q, st_d;
   logic       sw_entry, loss_entry;

   assign sw_entry   = hib_req & ~(bat_low & lb_no_entry);
   assign loss_entry = main_loss & bat_valid;
   assign req_clr    = (st_q == ST_RUN) & clk_en & hib_req;
   assign wake_take  = (st_q == ST_HIB) & clk_en & any_hit & ~(bat_low & lb_no_wake);

   always_comb begin
      st_d = st_q;
      if (clk_en) begin
         unique case (st_q)
            ST_RUN: if (sw_entry || loss_entry) st_d = ST_HIB;
            ST_HIB: if (wake_take) st_d = ST_RUN;
            default: st_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RUN;
      else        st_q <= st_d;
   end

   assign hib_o = (st_q == ST_HIB);
endmodule

// File: rtl/hib_cause_reg.sv
module hib_cause_reg #(
   parameter int NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [NBITS-1:0] set_vec,
   input  logic             clr_wr,
   input  logic [NBITS-1:0] clr_vec,
   output logic [NBITS-1:0] cause
);
   logic [NBITS-1:0] set_m, clr_m;

   assign set_m = set_en ? set_vec : '0;
   assign clr_m = clr_wr ? clr_vec : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause <= '0;
      else        cause <= (cause & ~clr_m) | set_m;
   end
endmodule

// File: rtl/hib_pwr_ctrl.sv
module hib_pwr_ctrl
   import hib_pkg::*;
#(
   parameter int GPIO_N = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CTRL_W-1:0] cfg_wdata,
   input  logic [GPIO_N-1:0] gpio_wake_mask,
   input  logic              sts_clr_wr,
   input  logic [NSRC-1:0]   sts_clr_mask,
   input  logic              main_loss,
   input  logic              bat_valid,
   input  logic              bat_low,
   input  logic              wake_pin,
   input  logic              rst_pin,
   input  logic [GPIO_N-1:0] gpio_in,
   input  logic              rtc_match,
   output logic              hib_o,
   output logic              req_pending,
   output logic [NSRC-1:0]   wake_cause
);
   generate
      if (GPIO_N < 1 || GPIO_N > 32) begin : g_bad_gpio_n
         $error("hib_pwr_ctrl: GPIO_N must be within 1..32");
      end
   endgenerate

   hib_ctrl_t       ctrl_q;
   logic            req_clr, wake_take, any_hit;
   logic [NSRC-1:0] src_en, src_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (cfg_wr)  ctrl_q <= hib_ctrl_t'(cfg_wdata);
      else if (req_clr) ctrl_q.hib_req <= 1'b0;
   end

   assign src_en = {ctrl_q.en_rtc, ctrl_q.en_gpio, ctrl_q.en_rst, ctrl_q.en_pin};

   hib_wake_arb #(.GPIO_N(GPIO_N)) u_arb (
      .src_en   (src_en),
      .wake_pin (wake_pin),
      .rst_pin  (rst_pin),
      .gpio_in  (gpio_in),
      .gpio_mask(gpio_wake_mask),
      .rtc_match(rtc_match),
      .src_hit  (src_hit),
      .any_hit  (any_hit)
   );

   hib_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en     (ctrl_q.clk_en),
      .hib_req    (ctrl_q.hib_req),
      .lb_no_entry(ctrl_q.lb_no_entry),
      .lb_no_wake (ctrl_q.lb_no_wake),
      .bat_low    (bat_low),
      .main_loss  (main_loss),
      .bat_valid  (bat_valid),
      .any_hit    (any_hit),
      .hib_o      (hib_o),
      .req_clr    (req_clr),
      .wake_take  (wake_take)
   );

   hib_cause_reg #(.NBITS(NSRC)) u_cause (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wake_take),
      .set_vec(src_hit),
      .clr_wr (sts_clr_wr),
      .clr_vec(sts_clr_mask),
      .cause  (wake_cause)
   );

   assign req_pending = ctrl_q.hib_req;
endmodule

// File: rtl/hib_pwr_ctrl_chk.sv
module hib_pwr_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hib_o,
   input logic       clk_en,
   input logic       lb_no_entry,
   input logic       lb_no_wake,
   input logic       bat_low,
   input logic       main_loss,
   input logic       bat_valid,
   input logic       any_hit,
   input logic       req_pending,
   input logic       cfg_wr,
   input logic       sts_clr_wr,
   input logic [3:0] wake_cause
);
   a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(hib_o));

   a_r3_loss_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!hib_o && clk_en && main_loss && bat_valid) |=> hib_o);

   a_r7_refuse_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!hib_o && bat_low && lb_no_entry && !(main_loss && bat_valid)) |=> !hib_o);

   a_r8_hold_low_bat: assert property (@(posedge clk) disable iff (!rst_n)
      (hib_o && bat_low && lb_no_wake) |=> hib_o);

   a_r4_wake_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      (hib_o && !any_hit) |=> hib_o);

   a_r11_req_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hib_o) && !$past(cfg_wr)) |-> !req_pending);

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_clr_wr |=> ((wake_cause & $past(wake_cause)) == $past(wake_cause)));
endmodule

bind hib_pwr_ctrl hib_pwr_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hib_o      (hib_o),
   .clk_en     (ctrl_q.clk_en),
   .lb_no_entry(ctrl_q.lb_no_entry),
   .lb_no_wake (ctrl_q.lb_no_wake),
   .bat_low    (bat_low),
   .main_loss  (main_loss),
   .bat_valid  (bat_valid),
   .any_hit    (any_hit),
   .req_pending(req_pending),
   .cfg_wr     (cfg_wr),
   .sts_clr_wr (sts_clr_wr),
   .wake_cause (wake_cause)
);

// File: tb/sim_hib_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_hib_pwr_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int GPIO_N = 4;

   logic clk = 0, rst_n = 0;
   logic cfg_wr = 0, sts_clr_wr = 0;
   logic [7:0] cfg_wdata = 0;
   logic [GPIO_N-1:0] gpio_wake_mask = 0, gpio_in = 0;
   logic [3:0] sts_clr_mask = 0;
   logic main_loss = 0, bat_valid = 0, bat_low = 0;
   logic wake_pin = 0, rst_pin = 0, rtc_match = 0;
   logic hib_o, req_pending;
   logic [3:0] wake_cause;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hib_pwr_ctrl #(.GPIO_N(GPIO_N)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .gpio_wake_mask(gpio_wake_mask), .sts_clr_wr(sts_clr_wr),
      .sts_clr_mask(sts_clr_mask), .main_loss(main_loss), .bat_valid(bat_valid),
      .bat_low(bat_low), .wake_pin(wake_pin), .rst_pin(rst_pin),
      .gpio_in(gpio_in), .rtc_match(rtc_match), .hib_o(hib_o),
      .req_pending(req_pending), .wake_cause(wake_cause));

   typedef struct {
      string      tag;
      logic       hib;
      logic [3:0] cause;
      logic       req;
      bit         chk_req;
   } exp_t;
   exp_t sb[$];

   // monitor: compare expected items against outputs away from the clock edge
   always @(negedge clk) begin
      while (sb.size() != 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (hib_o !== e.hib) begin
            fails++;
            $display("FAIL %s hib_o actual=%b expected=%b", e.tag, hib_o, e.hib);
         end
         checks++;
         if (wake_cause !== e.cause) begin
            fails++;
            $display("FAIL %s wake_cause actual=%b expected=%b", e.tag, wake_cause, e.cause);
         end
         if (e.chk_req) begin
            checks++;
            if (req_pending !== e.req) begin
               fails++;
               $display("FAIL %s req_pending actual=%b expected=%b", e.tag, req_pending, e.req);
            end
         end
      end
   end

   task automatic tick(string tag, logic hib, logic [3:0] cause,
                       logic req = 1'b0, bit chk_req = 1'b0);
      exp_t e;
      @(posedge clk);
      e.tag = tag; e.hib = hib; e.cause = cause; e.req = req; e.chk_req = chk_req;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic cfg(string tag, logic [7:0] v, logic hib, logic [3:0] cause, logic req);
      cfg_wr = 1; cfg_wdata = v;
      tick(tag, hib, cause, req, 1'b1);
      cfg_wr = 0;
   endtask

   task automatic clr(string tag, logic [3:0] m, logic hib, logic [3:0] cause);
      sts_clr_wr = 1; sts_clr_mask = m;
      tick(tag, hib, cause);
      sts_clr_wr = 0; sts_clr_mask = 0;
   endtask

   // software entry: write control with request, then expect entry next cycle
   task automatic enter_sw(string tag, logic [7:0] en, logic [3:0] cause);
      cfg(tag, en | 8'h03, 1'b0, cause, 1'b1);
      tick(tag, 1'b1, cause, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick("R1 reset state", 0, 4'h0, 1'b0, 1'b1);

      // R9: no clock enable, nothing happens
      cfg("R9 req without clk_en", 8'h02, 0, 4'h0, 1'b1);
      tick("R9 req held pending", 0, 4'h0, 1'b1, 1'b1);
      main_loss = 1; bat_valid = 1;
      tick("R9 supply loss ignored", 0, 4'h0, 1'b1, 1'b1);
      main_loss = 0; bat_valid = 0;
      cfg("R9 clear ctrl", 8'h00, 0, 4'h0, 1'b0);

      // R2 / R11 software entry, R5 disabled source, R4 pin wake
      enter_sw("R2 R11 software entry", 8'h04, 4'h0);
      rst_pin = 1;
      tick("R5 disabled rst_pin ignored", 1, 4'h0);
      rst_pin = 0;
      wake_pin = 1;
      tick("R4 wake pin", 0, 4'h1);
      wake_pin = 0;
      clr("R10 clear pin cause", 4'h1, 0, 4'h0);

      enter_sw("R2 entry for rst", 8'h08, 4'h0);
      rst_pin = 1;
      tick("R4 R10 reset pin wake", 0, 4'h2);
      rst_pin = 0;
      clr("R10 clear rst cause", 4'h2, 0, 4'h0);

      gpio_wake_mask = 4'b0100;
      enter_sw("R2 entry for gpio", 8'h10, 4'h0);
      gpio_in = 4'b0001;
      tick("R5 masked gpio ignored", 1, 4'h0);
      gpio_in = 4'b0100;
      tick("R4 R10 gpio wake", 0, 4'h4);
      gpio_in = 0;
      clr("R10 clear gpio cause", 4'h4, 0, 4'h0);

      enter_sw("R2 entry for rtc", 8'h20, 4'h0);
      rtc_match = 1;
      tick("R4 R10 rtc wake", 0, 4'h8);
      rtc_match = 0;

      // R6: several enabled, pin alone wakes; R10 sticky and partial clear
      enter_sw("R6 entry pin+rtc", 8'h24, 4'h8);
      wake_pin = 1;
      tick("R6 R10 pin wakes, rtc bit sticky", 0, 4'h9);
      wake_pin = 0;
      clr("R10 partial clear", 4'h8, 0, 4'h1);
      clr("R10 full clear", 4'h1, 0, 4'h0);

      // R3 supply loss entry
      cfg("R3 enable", 8'h05, 0, 4'h0, 1'b0);
      main_loss = 1;
      tick("R3 loss without battery", 0, 4'h0);
      bat_valid = 1;
      tick("R3 loss with battery", 1, 4'h0);
      main_loss = 0;
      wake_pin = 1;
      tick("R3 R4 wake after loss", 0, 4'h1);
      wake_pin = 0;
      clr("R10 clear", 4'h1, 0, 4'h0);

      // R7 low battery refuses software request, not supply loss
      bat_low = 1;
      cfg("R7 request with low battery", 8'h47, 0, 4'h0, 1'b1);
      tick("R7 R11 refused and consumed", 0, 4'h0, 1'b0, 1'b1);
      tick("R7 still running", 0, 4'h0);
      main_loss = 1;
      tick("R7 supply loss not blocked", 1, 4'h0);
      main_loss = 0;
      wake_pin = 1;
      tick("R7 wake allowed without wake block", 0, 4'h1);
      wake_pin = 0; bat_low = 0;
      clr("R10 clear", 4'h1, 0, 4'h0);

      // R8 low battery blocks wake; R10 set beats clear
      enter_sw("R8 entry", 8'h84, 4'h0);
      bat_low = 1; wake_pin = 1;
      tick("R8 wake suppressed", 1, 4'h0);
      bat_low = 0;
      sts_clr_wr = 1; sts_clr_mask = 4'h1;
      tick("R8 R10 wake after battery ok, set wins", 0, 4'h1);
      sts_clr_wr = 0; sts_clr_mask = 0; wake_pin = 0;
      clr("R10 final clear", 4'h1, 0, 4'h0);

      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule